// File: doc/BRIEF.md
# Shared Comparator Timer

A free-running 64-bit up-counter shared by up to four processors. Each processor owns one comparator channel. The counter advances once every (prescale + 1) clock cycles, but only while the shared run bit is set. Each channel holds a 64-bit compare value, a 32-bit step value, a sticky event flag and an interrupt line. When the count reaches the channel's compare value, the channel raises its event flag. If the channel is set to reload, it also adds its step value to the compare value, so that it keeps producing periodic events.

Software reaches the block through a 32-bit register port with a 0x20-byte window. A processor-index input travels with every access and picks which channel's banked registers that access reads or writes. The control word is split in two:

- The run bit and the prescale field are common to all processors.
- The compare-enable, interrupt-enable and reload bits belong to the accessing processor.

A control read merges the common bits with the accessing processor's banked bits.

Top module: `shared_cmp_timer`

## Requirements
- R1: After a synchronous reset, the following read as zero for every processor index, and all interrupt lines are low: the count, the common control bits, and each channel's banked bits, event flag, compare value and step value.
- R2: The count is 64 bits wide. Its low word is at offset 0x00 and its high word at 0x04. Writing a word while the run bit is clear replaces only that word.
- R3: While the run bit (control bit 0) is set, writes to 0x00 and 0x04 leave the count unchanged.
- R4: While running, the count advances by one every (P + 1) clock cycles, where P is control bits 15:8. A carry out of the low word reaches the high word. While the run bit is clear, the prescale phase returns to zero, so the first advance comes P + 1 cycles after the run bit is set.
- R5: On every clock edge where the run bit is set, the channel's compare-enable bit (control bit 1) is set, and the count is greater than or equal to the compare value, that channel's event flag (bit 0 at 0x0C) becomes 1.
- R6: When the reload bit (control bit 3) is set, each edge that sets the event flag also adds the step value (offset 0x18) to the compare value. At most one step is added per clock.
- R7: Each channel's interrupt output is high exactly while its event flag and its interrupt-enable bit (control bit 2) are both 1. It follows them in the same cycle.
- R8: Writing 0x0C with bit 0 set clears the event flag. Writing bit 0 as 0 leaves it unchanged. An event on the same edge as a clearing write leaves the flag set.
- R9: Bit 0 and bits 15:8 of a control write are common to all processors. Bits 3:1 are stored only for the accessing processor. A control read returns the common bits ORed with the accessing processor's bits 3:1.
- R10: The processor index picks the channel for offsets 0x08 to 0x18. An access with an index at or above the channel count changes nothing and reads zero.
- R11: Offset 0x1C, addresses whose two low bits are not zero, and cycles without select all read zero. Writes to them change nothing.
- R12: Offsets 0x10 and 0x14 replace the low and high word of the compare value. A compare write on the same edge as a reload step wins, and that step is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | CPU_IDX_W | Index of the accessing processor |
| bus_addr | input | 5 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from state and the current access |
| irq | output | NCPU | One interrupt line per channel |

## Verification
A wrong count or prescale phase shows up on the next counter read as a value one step early or late. Reading the count every cycle exposes it on the first edge where the bad value is used. A channel whose compare value or event flag has gone wrong shows it on its interrupt line, or on a flag or compare read, in the cycle after the bad edge. This holds even when the error is a missing or doubled reload step. A bank-select fault shows as one processor's control bits appearing in another processor's read in the same cycle.

// File: rtl/sct_pkg.sv
package sct_pkg;
    typedef enum logic [2:0] {
        RW_CNT_LO = 3'd0,
        RW_CNT_HI = 3'd1,
        RW_CTRL   = 3'd2,
        RW_FLAG   = 3'd3,
        RW_CMP_LO = 3'd4,
        RW_CMP_HI = 3'd5,
        RW_STEP   = 3'd6,
        RW_NONE   = 3'd7
    } reg_word_e;

    localparam int CB_RUN    = 0;
    localparam int CB_CMPEN  = 1;
    localparam int CB_IRQEN  = 2;
    localparam int CB_RELOAD = 3;
    localparam int CB_PRE_LO = 8;
endpackage

// File: rtl/sct_counter.sv
module sct_counter #(
    parameter int DATA_W = 32,
    parameter int PRE_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run_i,
    input  logic [PRE_W-1:0]      presc_i,
    input  logic                  ld_lo_i,
    input  logic                  ld_hi_i,
    input  logic [DATA_W-1:0]     ld_data_i,
    output logic [2*DATA_W-1:0]   count_o
);
    localparam int CNT_W = 2 * DATA_W;

    logic [PRE_W-1:0] phase_q;
    logic             tick;

    assign tick = run_i && (phase_q >= presc_i);

    always_ff @(posedge clk) begin
        if (rst || !run_i || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_o <= '0;
        end else if (run_i) begin
            if (tick) begin
                count_o <= count_o + CNT_W'(1);
            end
        end else if (ld_lo_i) begin
            count_o[DATA_W-1:0] <= ld_data_i;
        end else if (ld_hi_i) begin
            count_o[CNT_W-1:DATA_W] <= ld_data_i;
        end
    end

    // R3: no load takes effect while running
    assert_no_load_running_R3: assert property (@(posedge clk) disable iff (rst)
        (run_i && (ld_lo_i || ld_hi_i)) |=>
            (count_o == $past(count_o) || count_o == $past(count_o) + CNT_W'(1)));

    // R4: the count never moves by more than one per clock
    assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
        run_i |=> (count_o == $past(count_o) || count_o == $past(count_o) + CNT_W'(1)));

    // R4: stopped and untouched means frozen
    assert_frozen_when_off_R4: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !ld_lo_i && !ld_hi_i) |=> $stable(count_o));
endmodule

// File: rtl/sct_channel.sv
module sct_channel #(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run_i,
    input  logic [2*DATA_W-1:0]   count_i,
    input  logic                  wr_ctrl_i,
    input  logic                  wr_flag_i,
    input  logic                  wr_cmp_lo_i,
    input  logic                  wr_cmp_hi_i,
    input  logic                  wr_step_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [2*DATA_W-1:0]   cmp_o,
    output logic [DATA_W-1:0]     step_o,
    output logic [2:0]            bank_o,
    output logic                  flag_o,
    output logic                  irq_o
);
    import sct_pkg::*;
    localparam int CNT_W = 2 * DATA_W;

    logic cmpen_q, irqen_q, reload_q, hit;

    assign hit    = run_i && cmpen_q && (count_i >= cmp_o);
    assign bank_o = {reload_q, irqen_q, cmpen_q};
    assign irq_o  = flag_o && irqen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmpen_q  <= 1'b0;
            irqen_q  <= 1'b0;
            reload_q <= 1'b0;
            step_o   <= '0;
        end else begin
            if (wr_ctrl_i) begin
                cmpen_q  <= wdata_i[CB_CMPEN];
                irqen_q  <= wdata_i[CB_IRQEN];
                reload_q <= wdata_i[CB_RELOAD];
            end
            if (wr_step_i) begin
                step_o <= wdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
        end else if (hit) begin
            flag_o <= 1'b1;
        end else if (wr_flag_i && wdata_i[0]) begin
            flag_o <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_o <= '0;
        end else if (wr_cmp_lo_i) begin
            cmp_o[DATA_W-1:0] <= wdata_i;
        end else if (wr_cmp_hi_i) begin
            cmp_o[CNT_W-1:DATA_W] <= wdata_i;
        end else if (hit && reload_q) begin
            cmp_o <= cmp_o + CNT_W'(step_o);
        end
    end

    // R5: a match always leaves the flag set
    assert_match_sets_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (run_i && cmpen_q && count_i >= cmp_o) |=> flag_o);

    // R6: a reload match moves the compare value by exactly one step
    assert_reload_step_R6: assert property (@(posedge clk) disable iff (rst)
        (hit && reload_q && !wr_cmp_lo_i && !wr_cmp_hi_i) |=>
            cmp_o == $past(cmp_o) + CNT_W'($past(step_o)));

    // R8: the flag only falls through a clearing write
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !(wr_flag_i && wdata_i[0])) |=> flag_o);
endmodule

// File: rtl/shared_cmp_timer.sv
module shared_cmp_timer #(
    parameter int NCPU      = 4,
    parameter int CPU_IDX_W = 3,
    parameter int DATA_W    = 32,
    parameter int PRE_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [CPU_IDX_W-1:0]  bus_cpu,
    input  logic [4:0]            bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [NCPU-1:0]       irq
);
    import sct_pkg::*;
    localparam int CNT_W = 2 * DATA_W;

    logic              run_q;
    logic [PRE_W-1:0]  presc_q;
    logic [CNT_W-1:0]  count;
    logic              acc_ok, wr_ok;
    reg_word_e         word;

    logic [CNT_W-1:0]  ch_cmp  [NCPU];
    logic [DATA_W-1:0] ch_step [NCPU];
    logic [2:0]        ch_bank [NCPU];
    logic [NCPU-1:0]   ch_flag;

    assign acc_ok = bus_sel && (bus_addr[1:0] == 2'b00) && (32'(bus_cpu) < NCPU);
    assign wr_ok  = acc_ok && bus_wr;
    assign word   = reg_word_e'(bus_addr[4:2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            presc_q <= '0;
        end else if (wr_ok && word == RW_CTRL) begin
            run_q   <= bus_wdata[CB_RUN];
            presc_q <= bus_wdata[CB_PRE_LO +: PRE_W];
        end
    end

    sct_counter #(.DATA_W(DATA_W), .PRE_W(PRE_W)) u_counter (
        .clk       (clk),
        .rst       (rst),
        .run_i     (run_q),
        .presc_i   (presc_q),
        .ld_lo_i   (wr_ok && word == RW_CNT_LO),
        .ld_hi_i   (wr_ok && word == RW_CNT_HI),
        .ld_data_i (bus_wdata),
        .count_o   (count)
    );

    for (genvar i = 0; i < NCPU; i++) begin : g_chan
        logic mine;
        assign mine = wr_ok && (bus_cpu == CPU_IDX_W'(i));

        sct_channel #(.DATA_W(DATA_W)) u_chan (
            .clk         (clk),
            .rst         (rst),
            .run_i       (run_q),
            .count_i     (count),
            .wr_ctrl_i   (mine && word == RW_CTRL),
            .wr_flag_i   (mine && word == RW_FLAG),
            .wr_cmp_lo_i (mine && word == RW_CMP_LO),
            .wr_cmp_hi_i (mine && word == RW_CMP_HI),
            .wr_step_i   (mine && word == RW_STEP),
            .wdata_i     (bus_wdata),
            .cmp_o       (ch_cmp[i]),
            .step_o      (ch_step[i]),
            .bank_o      (ch_bank[i]),
            .flag_o      (ch_flag[i]),
            .irq_o       (irq[i])
        );
    end

    always_comb begin
        logic [CNT_W-1:0]  s_cmp;
        logic [DATA_W-1:0] s_step;
        logic [2:0]        s_bank;
        logic              s_flag;
        s_cmp  = '0;
        s_step = '0;
        s_bank = '0;
        s_flag = 1'b0;
        for (int i = 0; i < NCPU; i++) begin
            if (bus_cpu == CPU_IDX_W'(i)) begin
                s_cmp  = ch_cmp[i];
                s_step = ch_step[i];
                s_bank = ch_bank[i];
                s_flag = ch_flag[i];
            end
        end
        bus_rdata = '0;
        if (acc_ok) begin
            unique case (word)
                RW_CNT_LO: bus_rdata = count[DATA_W-1:0];
                RW_CNT_HI: bus_rdata = count[CNT_W-1:DATA_W];
                RW_CTRL: begin
                    bus_rdata[CB_RUN]             = run_q;
                    bus_rdata[CB_RELOAD:CB_CMPEN] = s_bank;
                    bus_rdata[CB_PRE_LO +: PRE_W] = presc_q;
                end
                RW_FLAG:   bus_rdata[0] = s_flag;
                RW_CMP_LO: bus_rdata = s_cmp[DATA_W-1:0];
                RW_CMP_HI: bus_rdata = s_cmp[CNT_W-1:DATA_W];
                RW_STEP:   bus_rdata = s_step;
                RW_NONE:   bus_rdata = '0;
            endcase
        end
    end

    // R10: an out-of-range processor index reads nothing
    assert_bad_cpu_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && 32'(bus_cpu) >= NCPU) |-> bus_rdata == '0);

    // R11: misaligned offsets read nothing
    assert_misaligned_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[1:0] != 2'b00) |-> bus_rdata == '0);
endmodule

// File: tb/tb_shared_cmp_timer.sv
`timescale 1ns/1ps
module tb_shared_cmp_timer;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_cpu = '0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NC-1:0] irq;

    int vectors = 0, fails = 0;
    bit chk_on = 0, done = 0;

    always #2.5 clk = ~clk;

    shared_cmp_timer dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // behavioural reference state
    logic [63:0] m_cnt;
    int          m_phase;
    bit          m_run;
    int          m_pre;
    logic [63:0] m_cmp  [NC];
    logic [31:0] m_step [NC];
    bit          m_cen [NC], m_ien [NC], m_rel [NC], m_flag [NC];

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_phase = 0; m_run = 0; m_pre = 0;
            for (int i = 0; i < NC; i++) begin
                m_cmp[i] = 0; m_step[i] = 0;
                m_cen[i] = 0; m_ien[i] = 0; m_rel[i] = 0; m_flag[i] = 0;
            end
        end else begin
            bit ok, w, hit;
            int c, wd;
            bit o_run;
            int o_pre;
            logic [63:0] o_cnt;
            ok = bus_sel && bus_addr[1:0] == 0 && int'(bus_cpu) < NC;
            w = ok && bus_wr;
            c = int'(bus_cpu);
            wd = int'(bus_addr[4:2]);
            o_run = m_run; o_pre = m_pre; o_cnt = m_cnt;
            for (int i = 0; i < NC; i++) begin
                bit cmpw;
                cmpw = w && c == i && (wd == 4 || wd == 5);
                hit = o_run && m_cen[i] && (o_cnt >= m_cmp[i]);
                if (hit) begin
                    m_flag[i] = 1;
                    if (m_rel[i] && !cmpw) m_cmp[i] = m_cmp[i] + {32'd0, m_step[i]};
                end
                if (w && c == i) begin
                    case (wd)
                        2: begin m_cen[i] = bus_wdata[1]; m_ien[i] = bus_wdata[2]; m_rel[i] = bus_wdata[3]; end
                        3: if (!hit && bus_wdata[0]) m_flag[i] = 0;
                        4: m_cmp[i][31:0] = bus_wdata;
                        5: m_cmp[i][63:32] = bus_wdata;
                        6: m_step[i] = bus_wdata;
                        default: ;
                    endcase
                end
            end
            if (o_run) begin
                if (m_phase >= o_pre) begin m_cnt = m_cnt + 1; m_phase = 0; end
                else m_phase = m_phase + 1;
            end else begin
                m_phase = 0;
                if (w && wd == 0) m_cnt[31:0] = bus_wdata;
                if (w && wd == 1) m_cnt[63:32] = bus_wdata;
            end
            if (w && wd == 2) begin m_run = bus_wdata[0]; m_pre = int'(bus_wdata[15:8]); end
        end
    end

    function automatic logic [31:0] exp_read();
        int c;
        c = int'(bus_cpu);
        if (!bus_sel || bus_addr[1:0] != 0 || c >= NC) return 32'd0;
        case (int'(bus_addr[4:2]))
            0: return m_cnt[31:0];
            1: return m_cnt[63:32];
            2: return {16'd0, 8'(m_pre), 4'd0, m_rel[c], m_ien[c], m_cen[c], m_run};
            3: return {31'd0, m_flag[c]};
            4: return m_cmp[c][31:0];
            5: return m_cmp[c][63:32];
            6: return m_step[c];
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of();
        if (!bus_sel || bus_addr[1:0] != 0 || bus_addr[4:2] == 7) return "R11";
        if (int'(bus_cpu) >= NC) return "R10";
        case (int'(bus_addr[4:2]))
            0, 1: return "R2/R4";
            2: return "R9";
            3: return "R5/R8";
            4, 5: return "R6/R12";
            default: return "R6";
        endcase
    endfunction

    always @(negedge clk) begin
        if (chk_on) begin
            logic [31:0] e;
            logic [NC-1:0] ei;
            e = exp_read();
            vectors++;
            if (bus_rdata !== e) begin
                fails++;
                $display("FAIL %s: cpu %0d addr 0x%02h read 0x%08h expected 0x%08h at %0t",
                         req_of(), bus_cpu, bus_addr, bus_rdata, e, $time);
            end
            for (int i = 0; i < NC; i++) ei[i] = m_flag[i] && m_ien[i];
            vectors++;
            if (irq !== ei) begin
                fails++;
                $display("FAIL R7: irq 0x%0h expected 0x%0h at %0t", irq, ei, $time);
            end
        end
    end

    task automatic drive(input bit s, input bit w, input int c, input int a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = s; bus_wr = w; bus_cpu = 3'(c); bus_addr = 5'(a); bus_wdata = d;
    endtask

    task automatic wr(input int c, input int a, input logic [31:0] d);
        drive(1, 1, c, a, d);
        drive(1, 0, c, a, 0);
    endtask

    task automatic watch(input int c, input int a, input int n);
        for (int k = 0; k < n; k++) drive(1, 0, c, a, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0; chk_on = 1;
        // R1: everything reads zero after reset
        for (int c = 0; c < NC; c++)
            for (int a = 0; a < 32; a += 4) watch(c, a, 1);
        // R2: load both words while stopped
        wr(0, 'h00, 32'hFFFF_FFFE);
        wr(0, 'h04, 32'h0000_0001);
        watch(0, 'h04, 2);
        // R4: run with prescale 2, carry into the high word
        wr(0, 'h08, 32'h0000_0201);
        watch(0, 'h00, 5);
        watch(0, 'h04, 10);
        // R3: loads ignored while running
        wr(0, 'h00, 32'h1234_5678);
        wr(0, 'h04, 32'h0000_00AA);
        watch(0, 'h04, 3);
        // R9: banked bits of cpu1, common bits rewritten
        wr(1, 'h08, 32'h0000_0007);
        watch(0, 'h08, 2);
        watch(1, 'h08, 2);
        watch(2, 'h08, 1);
        // stop, reload count 0, run at full rate
        wr(0, 'h08, 32'h0);
        wr(0, 'h04, 32'h0);
        wr(0, 'h00, 32'h0);
        // R5 R6 R7: cpu0 periodic with step 5 from compare 10
        wr(0, 'h10, 32'd10);
        wr(0, 'h18, 32'd5);
        wr(0, 'h08, 32'h0000_000F);
        watch(0, 'h0C, 14);
        watch(0, 'h10, 6);
        // R8: writing 0 keeps the flag, writing 1 clears it
        wr(0, 'h0C, 32'h0);
        wr(0, 'h0C, 32'h1);
        watch(0, 'h0C, 12);
        // R5: cpu2 one-shot, no reload, irq enable off then on
        wr(2, 'h10, 32'd60);
        wr(2, 'h08, 32'h0000_0003);
        watch(2, 'h0C, 20);
        wr(2, 'h08, 32'h0000_0007);
        // R8: clear while match persists keeps the flag
        wr(2, 'h0C, 32'h1);
        watch(2, 'h0C, 2);
        // R6: catch-up one step per clock from a far-behind compare
        wr(3, 'h10, 32'd0);
        wr(3, 'h18, 32'd3);
        wr(3, 'h08, 32'h0000_000B);
        watch(3, 'h10, 40);
        // R12: compare write beats the reload step; high word write
        wr(3, 'h18, 32'd0);
        wr(3, 'h10, 32'd2);
        wr(3, 'h14, 32'h0000_0100);
        watch(3, 'h14, 3);
        wr(3, 'h0C, 32'h1);
        watch(3, 'h0C, 3);
        // R10: out-of-range index changes nothing and reads zero
        wr(5, 'h08, 32'h0000_0000);
        wr(7, 'h10, 32'hDEAD_BEEF);
        watch(6, 'h00, 2);
        watch(0, 'h08, 2);
        // R11: undefined and misaligned offsets, deselected reads
        wr(0, 'h1C, 32'hFFFF_FFFF);
        wr(0, 'h0A, 32'h0);
        watch(0, 'h1C, 1);
        watch(0, 'h02, 1);
        drive(0, 0, 0, 'h00, 0);
        watch(0, 'h08, 3);
        // R4: prescale 0 vs 3 after restart of the phase
        wr(0, 'h08, 32'h0000_0000);
        wr(0, 'h08, 32'h0000_0301);
        watch(0, 'h00, 12);
        // R1: reset mid-run clears everything again
        @(posedge clk); #1 rst = 1; chk_on = 0;
        @(posedge clk); #1 rst = 0; chk_on = 1;
        for (int c = 0; c < NC; c++)
            for (int a = 0; a < 28; a += 4) watch(c, a, 1);
        @(posedge clk); #1;
        done = 1;
        chk_on = 0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run still active, expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule